// File: doc/BRIEF.md
# Host SPI Router with Configuration and Status Port

This block sits between one host SPI bus and a group of downstream SPI devices: one attenuator chain and four synthesizer channels. The host drives a 3-bit select code, not individual chip selects. The block decodes that code. It either raises the select line of one downstream device, raises all four synthesizer selects at once, or attaches the host to the block's own 24-bit register port. While a downstream device is selected, the host serial clock and data are forwarded to the device, and the device's data output is returned to the host.

On its own port the block works as a full-duplex shift register, most significant bit first, with clock idle low and data sampled on the rising edge. A new control word is shifted in while a status word, captured at the start of the frame, is shifted out. The control word is accepted only if the frame carried exactly 24 bits. It drives the RF switch enables, the LEDs, the profile select, the I/O update line, the mask, the clock and sync source selects, the device reset and the I/O reset. Each RF switch output is also forced on by an external line.

The serial inputs are synchronized into the system clock domain for the register port. The forwarding and select paths are purely combinational.

Top module: `spi_router_top`

## Requirements
- R1: Select code 2 raises only `att_sel`. Code 3 raises all four `ch_sel` bits. Codes 4, 5, 6 and 7 raise only `ch_sel[0]`, `[1]`, `[2]` and `[3]` respectively. Codes 0 and 1 raise no downstream select.
- R2: `host_miso` returns `att_miso` for code 2, `ch_miso[0]` for code 3, and `ch_miso[code-4]` for codes 4 to 7. For code 0 it is low.
- R3: `dn_sclk` and `dn_mosi` equal `host_sclk` and `host_mosi` while code 2 to 7 is applied, and are low for codes 0 and 1.
- R4: Code 1 opens a register frame. MOSI is sampled on each rising `host_sclk`, first bit = bit 23. When the code leaves 1 after exactly 24 bits, the word is committed: rf_sw[3:0], led[7:4], profile[10:8], io_update[12], mask[16:13], clk_sel[17], sync_sel[18], dds_rst[19], io_rst[20]. Bits 11 and 23:21 are ignored.
- R5: A register frame that ends with any bit count other than 24 leaves every control output unchanged.
- R6: During a register frame `host_miso` carries a 24-bit status word, MSB first, captured when the frame opens. Bit 23 is valid before the first rising edge, and each later bit follows a falling edge. Layout: RF switch state (control bits OR external lines) [3:0], `smp_err` [7:4], `pll_lock` [11:8], `ifc_mode` [15:12], protocol revision 0x08 [22:16], zero [23].
- R7: `rf_sw` is the bitwise OR of the committed RF switch bits and `sw_ext`, and follows `sw_ext` without a frame.
- R8: After reset every control output is 0, so clock and sync select point to their internal sources.
- R9: `io_update`, `dds_rst` and `io_rst` are levels. They stay at the written value through idle time until a later frame rewrites them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sclk | input | 1 | Host serial clock |
| host_mosi | input | 1 | Host serial data in |
| host_cs | input | 3 | Encoded select code, 0 = idle |
| host_miso | output | 1 | Serial data returned to host |
| dn_sclk | output | 1 | Forwarded serial clock |
| dn_mosi | output | 1 | Forwarded serial data |
| att_sel | output | 1 | Attenuator chain select, active high |
| att_miso | input | 1 | Attenuator chain data out |
| ch_sel | output | 4 | Synthesizer channel selects, active high |
| ch_miso | input | 4 | Synthesizer channel data outs |
| sw_ext | input | 4 | External RF switch force lines |
| smp_err | input | 4 | Sample error flags reported in status |
| pll_lock | input | 4 | PLL lock flags reported in status |
| ifc_mode | input | 4 | Interface mode reported in status |
| rf_sw | output | 4 | RF switch enables |
| led | output | 4 | LED drives |
| profile | output | 3 | Profile select |
| io_update | output | 1 | I/O update level |
| mask | output | 4 | Mask field |
| clk_sel | output | 1 | Reference clock source select |
| sync_sel | output | 1 | Sync clock source select |
| dds_rst | output | 1 | Synthesizer reset level |
| io_rst | output | 1 | Synthesizer I/O reset level |

## Verification
Two events can land close together: the commit at the end of one register frame and the status capture at the opening of the next. The bench closes one frame and reopens code 1 after only four system clocks. It then checks that the RF switch field in the second status word already includes the bits committed by the first frame. A second collision is an external switch line changing while a committed value is held. There `rf_sw` must show the OR of both sources at once, with no other control output moving.

// File: rtl/spi_router_pkg.sv
package spi_router_pkg;

    localparam int FRAME_BITS = 24;
    localparam int CODE_W     = 3;
    localparam int N_CH       = 4;
    localparam int CNT_W      = $clog2(FRAME_BITS + 2);

    typedef enum logic [CODE_W-1:0] {
        SEL_IDLE = 3'd0,
        SEL_REG  = 3'd1,
        SEL_ATTN = 3'd2,
        SEL_ALL  = 3'd3,
        SEL_CH0  = 3'd4,
        SEL_CH1  = 3'd5,
        SEL_CH2  = 3'd6,
        SEL_CH3  = 3'd7
    } sel_code_e;

    // control word, LSB field last
    typedef struct packed {
        logic [2:0]      spare_hi;
        logic            io_rst;
        logic            dds_rst;
        logic            sync_sel;
        logic            clk_sel;
        logic [3:0]      mask;
        logic            io_update;
        logic            spare_11;
        logic [2:0]      profile;
        logic [3:0]      led;
        logic [N_CH-1:0] rf_sw;
    } ctrl_t;

    typedef struct packed {
        logic            zero;
        logic [6:0]      rev;
        logic [3:0]      ifc_mode;
        logic [3:0]      pll_lock;
        logic [3:0]      smp_err;
        logic [N_CH-1:0] rf_state;
    } stat_t;

    typedef struct packed {
        logic            own;
        logic            att;
        logic [N_CH-1:0] ch;
    } route_t;

    function automatic route_t decode_sel(logic [CODE_W-1:0] code);
        route_t r;
        r = '0;
        case (code)
            SEL_REG:  r.own = 1'b1;
            SEL_ATTN: r.att = 1'b1;
            SEL_ALL:  r.ch  = '1;
            SEL_CH0, SEL_CH1, SEL_CH2, SEL_CH3: r.ch[code[1:0]] = 1'b1;
            default:  r = '0;
        endcase
        return r;
    endfunction

    function automatic stat_t build_stat(logic [6:0] rev, logic [N_CH-1:0] rf,
                                         logic [3:0] smp, logic [3:0] lock,
                                         logic [3:0] ifc);
        stat_t s;
        s.zero     = 1'b0;
        s.rev      = rev;
        s.ifc_mode = ifc;
        s.pll_lock = lock;
        s.smp_err  = smp;
        s.rf_state = rf;
        return s;
    endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_reg_engine.sv
module spi_reg_engine
    import spi_router_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sclk_s,
    input  logic                  mosi_s,
    input  logic                  sel_s,
    input  stat_t                 stat_in,
    output logic                  tx_bit,
    output logic                  commit,
    output logic [FRAME_BITS-1:0] word
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

    logic                  sclk_q, sel_q;
    logic [FRAME_BITS-1:0] rx_sr, tx_sr;
    logic [CNT_W-1:0]      bit_cnt;
    logic                  rise, fall, open_f, close_f;

    assign rise    = sclk_s & ~sclk_q;
    assign fall    = ~sclk_s & sclk_q;
    assign open_f  = sel_s & ~sel_q;
    assign close_f = ~sel_s & sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q  <= 1'b0;
            sel_q   <= 1'b0;
            rx_sr   <= '0;
            tx_sr   <= '0;
            bit_cnt <= '0;
            commit  <= 1'b0;
        end else begin
            sclk_q <= sclk_s;
            sel_q  <= sel_s;
            commit <= close_f && (bit_cnt == CNT_FULL);
            if (open_f) begin
                tx_sr   <= stat_in;
                bit_cnt <= '0;
            end else if (sel_s) begin
                if (rise) begin
                    rx_sr <= {rx_sr[FRAME_BITS-2:0], mosi_s};
                    if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
                end
                if (fall) tx_sr <= {tx_sr[FRAME_BITS-2:0], 1'b0};
            end
        end
    end

    assign tx_bit = tx_sr[FRAME_BITS-1];
    assign word   = rx_sr;
endmodule

// File: rtl/spi_route.sv
module spi_route
    import spi_router_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic              host_sclk,
    input  logic              host_mosi,
    input  logic              own_bit,
    input  logic              att_miso,
    input  logic [N_CH-1:0]   ch_miso,
    output logic              att_sel,
    output logic [N_CH-1:0]   ch_sel,
    output logic              dn_sclk,
    output logic              dn_mosi,
    output logic              host_miso
);
    route_t rt;
    logic   dn_any;

    assign rt      = decode_sel(code);
    assign att_sel = rt.att;
    assign dn_any  = rt.att | (|rt.ch);

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        assign ch_sel[g] = rt.ch[g];
    end

    assign dn_sclk = host_sclk & dn_any;
    assign dn_mosi = host_mosi & dn_any;

    always_comb begin
        case (code)
            SEL_REG:  host_miso = own_bit;
            SEL_ATTN: host_miso = att_miso;
            SEL_ALL:  host_miso = ch_miso[0];
            SEL_CH0, SEL_CH1, SEL_CH2, SEL_CH3: host_miso = ch_miso[code[1:0]];
            default:  host_miso = 1'b0;
        endcase
    end
endmodule

// File: rtl/spi_router_top.sv
module spi_router_top
    import spi_router_pkg::*;
#(
    parameter logic [6:0] PROTO_REV   = 7'h08,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_sclk,
    input  logic              host_mosi,
    input  logic [CODE_W-1:0] host_cs,
    output logic              host_miso,
    output logic              dn_sclk,
    output logic              dn_mosi,
    output logic              att_sel,
    input  logic              att_miso,
    output logic [N_CH-1:0]   ch_sel,
    input  logic [N_CH-1:0]   ch_miso,
    input  logic [N_CH-1:0]   sw_ext,
    input  logic [3:0]        smp_err,
    input  logic [3:0]        pll_lock,
    input  logic [3:0]        ifc_mode,
    output logic [N_CH-1:0]   rf_sw,
    output logic [3:0]        led,
    output logic [2:0]        profile,
    output logic              io_update,
    output logic [3:0]        mask,
    output logic              clk_sel,
    output logic              sync_sel,
    output logic              dds_rst,
    output logic              io_rst
);
    logic [2:0]            raw_in, syn_in;
    logic                  own_sel;
    logic                  own_bit;
    logic                  cfg_commit;
    logic [FRAME_BITS-1:0] rx_word;
    ctrl_t                 cfg_q;
    stat_t                 stat_now;

    assign own_sel = (host_cs == SEL_REG);
    assign raw_in  = {own_sel, host_sclk, host_mosi};

    spi_in_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (syn_in)
    );

    assign stat_now = build_stat(PROTO_REV, cfg_q.rf_sw | sw_ext,
                                 smp_err, pll_lock, ifc_mode);

    spi_reg_engine u_eng (
        .clk     (clk),
        .rst     (rst),
        .sclk_s  (syn_in[1]),
        .mosi_s  (syn_in[0]),
        .sel_s   (syn_in[2]),
        .stat_in (stat_now),
        .tx_bit  (own_bit),
        .commit  (cfg_commit),
        .word    (rx_word)
    );

    always_ff @(posedge clk) begin
        if (rst)             cfg_q <= '0;
        else if (cfg_commit) cfg_q <= ctrl_t'(rx_word);
    end

    spi_route u_route (
        .code      (host_cs),
        .host_sclk (host_sclk),
        .host_mosi (host_mosi),
        .own_bit   (own_bit),
        .att_miso  (att_miso),
        .ch_miso   (ch_miso),
        .att_sel   (att_sel),
        .ch_sel    (ch_sel),
        .dn_sclk   (dn_sclk),
        .dn_mosi   (dn_mosi),
        .host_miso (host_miso)
    );

    assign rf_sw     = cfg_q.rf_sw | sw_ext;
    assign led       = cfg_q.led;
    assign profile   = cfg_q.profile;
    assign io_update = cfg_q.io_update;
    assign mask      = cfg_q.mask;
    assign clk_sel   = cfg_q.clk_sel;
    assign sync_sel  = cfg_q.sync_sel;
    assign dds_rst   = cfg_q.dds_rst;
    assign io_rst    = cfg_q.io_rst;
endmodule

// File: rtl/spi_router_chk.sv
module spi_router_chk (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  host_cs,
    input logic        host_miso,
    input logic        dn_sclk,
    input logic        att_sel,
    input logic [3:0]  ch_sel,
    input logic [3:0]  sw_ext,
    input logic [3:0]  rf_sw,
    input logic        commit,
    input logic [23:0] cfg_word
);
    p_att_alone_r1: assert property (@(posedge clk) disable iff (rst)
        att_sel |-> (ch_sel == 4'b0000));

    p_one_chan_r1: assert property (@(posedge clk) disable iff (rst)
        (host_cs >= 3'd4) |-> ($countones(ch_sel) == 1));

    p_idle_low_r2: assert property (@(posedge clk) disable iff (rst)
        (host_cs == 3'd0) |-> !host_miso);

    p_gated_clk_r3: assert property (@(posedge clk) disable iff (rst)
        !(att_sel || (|ch_sel)) |-> !dn_sclk);

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(cfg_word));

    p_force_r7: assert property (@(posedge clk) disable iff (rst)
        ((rf_sw & sw_ext) == sw_ext));
endmodule

bind spi_router_top spi_router_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .host_cs   (host_cs),
    .host_miso (host_miso),
    .dn_sclk   (dn_sclk),
    .att_sel   (att_sel),
    .ch_sel    (ch_sel),
    .sw_ext    (sw_ext),
    .rf_sw     (rf_sw),
    .commit    (cfg_commit),
    .cfg_word  (cfg_q)
);

// File: tb/sim_spi_router_top.sv
module sim_spi_router_top;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_sclk = 1'b0, host_mosi = 1'b0;
    logic [2:0] host_cs = 3'd0;
    logic       host_miso, dn_sclk, dn_mosi, att_sel;
    logic       att_miso = 1'b0;
    logic [3:0] ch_sel, ch_miso = 4'h0, sw_ext = 4'h0;
    logic [3:0] smp_err = 4'h0, pll_lock = 4'h0, ifc_mode = 4'h0;
    logic [3:0] rf_sw, led, mask;
    logic [2:0] profile;
    logic       io_update, clk_sel, sync_sel, dds_rst, io_rst;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [23:0] m_cfg = 24'h0;
    logic [31:0] rx_bits;

    always #2 clk = ~clk;

    spi_router_top u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] exp_sel(input logic [2:0] c);
        case (c)
            3'd2: return 5'b10000;
            3'd3: return 5'b01111;
            3'd4, 3'd5, 3'd6, 3'd7: return {1'b0, 4'b0001 << c[1:0]};
            default: return 5'b00000;
        endcase
    endfunction

    function automatic logic exp_miso(input logic [2:0] c, input logic am,
                                      input logic [3:0] cm);
        case (c)
            3'd2: return am;
            3'd3: return cm[0];
            3'd4, 3'd5, 3'd6, 3'd7: return cm[c[1:0]];
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [23:0] exp_stat();
        return {1'b0, 7'h08, ifc_mode, pll_lock, smp_err, m_cfg[3:0] | sw_ext};
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame(input logic [2:0] code, input int nbits,
                         input logic [31:0] data, input int gap);
        rx_bits = '0;
        host_cs = code;
        wait_clk(HALF);
        for (int i = 0; i < nbits; i++) begin
            host_mosi = data[nbits-1-i];
            wait_clk(HALF);
            rx_bits = {rx_bits[30:0], host_miso};
            host_sclk = 1'b1;
            wait_clk(HALF);
            host_sclk = 1'b0;
        end
        wait_clk(HALF);
        host_cs = 3'd0;
        host_mosi = 1'b0;
        wait_clk(gap);
        if (code == 3'd1 && nbits == 24) m_cfg = data[23:0];
    endtask

    task automatic check_ctrl(input string req);
        logic [23:0] act;
        act = {3'b0, io_rst, dds_rst, sync_sel, clk_sel, mask, io_update,
               1'b0, profile, led, 4'b0};
        chk(act == (m_cfg & 24'h1FF7F0), req, {8'h0, act}, {8'h0, m_cfg & 24'h1FF7F0});
        chk(rf_sw == (m_cfg[3:0] | sw_ext), {req, " rf R7"}, {28'h0, rf_sw},
            {28'h0, m_cfg[3:0] | sw_ext});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [23:0] st;
        void'($urandom(32'd4242));
        wait_clk(5);
        rst = 1'b0;
        wait_clk(3);
        // R8 reset state
        check_ctrl("R8 reset");
        chk(host_miso == 1'b0, "R8 idle miso", {31'h0, host_miso}, 32'h0);

        // R1 R2 directed codes
        for (int c = 0; c < 8; c++) begin
            att_miso = c[0];
            ch_miso  = 4'(c * 5 + 3);
            host_cs  = 3'(c);
            wait_clk(6);
            chk({att_sel, ch_sel} == exp_sel(3'(c)), "R1 decode",
                {27'h0, att_sel, ch_sel}, {27'h0, exp_sel(3'(c))});
            if (c != 1)
                chk(host_miso == exp_miso(3'(c), att_miso, ch_miso), "R2 miso",
                    {31'h0, host_miso}, {31'h0, exp_miso(3'(c), att_miso, ch_miso)});
            else
                chk(host_miso == 1'b0, "R6 status msb", {31'h0, host_miso}, 32'h0);
        end
        host_cs = 3'd0;
        wait_clk(6);

        // R1 R2 R3 random routing
        for (int k = 0; k < 40; k++) begin
            logic [2:0] c;
            c = 3'($urandom_range(0, 6));
            if (c >= 3'd1) c = c + 3'd1;
            att_miso  = 1'($urandom);
            ch_miso   = 4'($urandom);
            host_sclk = 1'($urandom);
            host_mosi = 1'($urandom);
            host_cs   = c;
            wait_clk(1);
            chk({att_sel, ch_sel} == exp_sel(c), "R1 random", {27'h0, att_sel, ch_sel},
                {27'h0, exp_sel(c)});
            chk(host_miso == exp_miso(c, att_miso, ch_miso), "R2 random",
                {31'h0, host_miso}, {31'h0, exp_miso(c, att_miso, ch_miso)});
            chk({dn_sclk, dn_mosi} == ((c >= 3'd2) ? {host_sclk, host_mosi} : 2'b00),
                "R3 forward", {30'h0, dn_sclk, dn_mosi},
                {30'h0, (c >= 3'd2) ? {host_sclk, host_mosi} : 2'b00});
            host_sclk = 1'b0;
            host_mosi = 1'b0;
            wait_clk(1);
        end
        host_cs = 3'd0;
        wait_clk(6);
        check_ctrl("R5 after routing");

        // R4 R6 R7 random register frames
        for (int k = 0; k < 6; k++) begin
            logic [23:0] d;
            d = 24'($urandom);
            sw_ext   = 4'($urandom);
            smp_err  = 4'($urandom);
            pll_lock = 4'($urandom);
            ifc_mode = 4'($urandom);
            st = exp_stat();
            frame(3'd1, 24, {8'h0, d}, 10);
            chk(rx_bits[23:0] == st, "R6 status word", rx_bits, {8'h0, st});
            check_ctrl("R4 commit");
        end

        // R5 short and long frames
        frame(3'd1, 23, 32'h7FFFFF, 10);
        check_ctrl("R5 short frame");
        frame(3'd1, 25, 32'h1FFFFFF, 10);
        check_ctrl("R5 long frame");
        frame(3'd1, 0, 32'h0, 10);
        check_ctrl("R5 empty frame");

        // R9 level outputs hold
        sw_ext = 4'h0;
        frame(3'd1, 24, 32'h1C1000 | {8'h0, m_cfg & 24'h000FFF}, 10);
        wait_clk(60);
        chk({io_rst, dds_rst, io_update} == 3'b111, "R9 held high",
            {29'h0, io_rst, dds_rst, io_update}, 32'h7);
        check_ctrl("R9 fields");
        frame(3'd1, 24, {8'h0, m_cfg & 24'hE6EFFF}, 10);
        wait_clk(60);
        chk({io_rst, dds_rst, io_update} == 3'b000, "R9 cleared",
            {29'h0, io_rst, dds_rst, io_update}, 32'h0);

        // back-to-back: commit then immediate status capture
        sw_ext = 4'h1;
        frame(3'd1, 24, 32'h00000A, 4);
        st = exp_stat();
        frame(3'd1, 24, 32'h000005, 10);
        chk(rx_bits[3:0] == 4'hB, "R6 back-to-back rf", {28'h0, rx_bits[3:0]}, 32'hB);
        chk(rx_bits[23:0] == st, "R6 back-to-back word", rx_bits, {8'h0, st});
        check_ctrl("R4 second commit");

        // R7 external line alone
        sw_ext = 4'hA;
        wait_clk(1);
        check_ctrl("R7 ext change");
        sw_ext = 4'h0;
        wait_clk(1);
        check_ctrl("R7 ext release");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule